// File: doc/BRIEF.md
# Memory Select Generator with Video Refresh Stretch

This block drives the active-low ROM and RAM selects of a small 8-bit computer built around a Z80-style CPU. It runs on a sampling clock at twice the CPU clock rate, so each sampling cycle is one half T-state. On every sampling cycle it receives the current CPU clock level (`cpu_phase`), the CPU strobes (`m1_n`, `mreq_n`, `rfsh_n`), address bit 14 and a flag from the video logic. The selects are combinational functions of these inputs and of a few registered values from the previous half. A 1 on the selects means not selected.

The display routine makes the CPU fetch opcodes from the display area. In the refresh cycle that follows such a fetch, slow ROM has to supply character pattern data to an external shifter. That shifter loads at the start of the next T1. To give the ROM time, the stretch variant holds the select asserted for one extra half clock after `/MREQ` goes high, but only in refresh cycles that belong to a video fetch.

A simpler variant enables ROM during every refresh cycle and has no stretch. A static parameter chooses between the two variants. A second parameter enables a mode in which the video logic's force-NOP signal disables both selects during T2 and T3 of an opcode fetch. This keeps memory off the bus while the NOP is forced.

Top module: `cs_decode`

## Requirements
- R1: Address bit 14 steers the select. With a14 = 0 only `rom_cs_n` may go low, and with a14 = 1 only `ram_cs_n` may go low. The two selects are never low together.
- R2: In the stretch variant (STRETCH_VARIANT = 1), with no stretch and no blanking, the active select is low exactly in the halves where `mreq_n` is 0. This holds in opcode fetch, memory read and refresh cycles.
- R3: In the stretch variant, the active select stays low for one more half after `mreq_n` rises. This happens only when all of the following are true: the previous half had `rfsh_n` = 0, the current half has `cpu_phase` = 0, and the video flag latched for this M1 cycle is 1. The select is released at the next rising CPU clock.
- R4: A refresh cycle whose latched video flag is 0 gets no stretch. An ordinary memory read gets no stretch, even if the latched video flag is 1.
- R5: The video flag is captured on the half in which `m1_n` falls. Changes to `video_en` later in that M1 cycle do not affect the stretch.
- R6: The stretch applies in the same way to `ram_cs_n` when a14 = 1.
- R7: In the refresh variant (STRETCH_VARIANT = 0), `rom_cs_n` is low when (`mreq_n` = 0 and a14 = 0) or `rfsh_n` = 0. `ram_cs_n` is low when `mreq_n` = 0, a14 = 1 and `rfsh_n` = 1.
- R8: With BLANK_ON_NOP = 1, `force_nop` = 1 forces both selects high during T2 and T3 of an opcode fetch. The T-states are counted as follows: T1 starts on the half in which `m1_n` falls, and the count advances on each rising edge of `cpu_phase`. Outside that window, `force_nop` has no effect. This includes T1, T4 and memory read cycles.
- R9: With BLANK_ON_NOP = 0, `force_nop` has no effect on either select.
- R10: After a synchronous reset (`rst_n` = 0) with idle strobes, both selects are high and the latched video flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, two cycles per CPU clock period |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_phase | input | 1 | CPU clock level in this half (1 = high half) |
| m1_n | input | 1 | CPU opcode-fetch strobe, active low |
| mreq_n | input | 1 | CPU memory request, active low |
| rfsh_n | input | 1 | CPU refresh strobe, active low |
| a14 | input | 1 | Address bit 14, picks RAM (1) or ROM (0) |
| video_en | input | 1 | Display fetch in progress, captured at `/M1` fall |
| force_nop | input | 1 | Video logic is forcing a NOP onto the data bus |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |

## Verification
The hardest case to reach is the single stretched half. It needs a refresh `/MREQ` rise during a low clock half, after a fetch whose flag was captured at the `/M1` fall, while `video_en` itself may already have changed. The stimulus replays complete opcode fetch and memory read cycles half by half. It sweeps the video flag at the fetch start and after it, along with `force_nop` and a14. A read cycle follows each fetch, so a stale latched flag meets a non-refresh `/MREQ` rise. Two instances, one per variant, see identical stimulus.

// File: rtl/cs_pkg.sv
// Shared types for the memory select generator.
// Assumes one sampling cycle per CPU half clock.
package cs_pkg;

    // Bus T-state as seen by the select logic; IDLE means outside a counted cycle.
    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_T4   = 3'd4
    } tstate_e;

endpackage

// File: rtl/cs_tstate_track.sv
// T-state tracker and video-flag latch.
// Restarts at T1 on the half where m1_n falls and advances on each rising
// edge of cpu_phase; after T4 it goes idle until the next fetch.
// Captures video_en on the /M1 fall half and holds it for the whole cycle.
// Assumes the strobes change at most once per sampling cycle.
module cs_tstate_track
    import cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cpu_phase,
    input  logic    m1_n,
    input  logic    video_en,
    output tstate_e t_now,
    output logic    vid_q
);

    logic    m1_prev;
    logic    phase_prev;
    tstate_e t_q;
    logic    m1_fall;
    logic    phase_rise;

    assign m1_fall    = m1_prev & ~m1_n;
    assign phase_rise = ~phase_prev & cpu_phase;

    // Current T-state from the held state and the edges seen in this half.
    always_comb begin
        if (m1_fall) begin
            t_now = TS_T1;
        end else if (phase_rise) begin
            case (t_q)
                TS_T1:   t_now = TS_T2;
                TS_T2:   t_now = TS_T3;
                TS_T3:   t_now = TS_T4;
                default: t_now = TS_IDLE;
            endcase
        end else begin
            t_now = t_q;
        end
    end

    // Hold the strobe history, the T-state and the captured video flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m1_prev    <= 1'b1;
            phase_prev <= 1'b1;
            t_q        <= TS_IDLE;
            vid_q      <= 1'b0;
        end else begin
            m1_prev    <= m1_n;
            phase_prev <= cpu_phase;
            t_q        <= t_now;
            if (m1_fall) begin
                vid_q <= video_en;
            end
        end
    end

    // R5: the flag changes only on a half that saw /M1 fall.
    assert_vid_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(m1_prev && !m1_n) |=> $stable(vid_q));

    // R8: T2 is followed by T2 again, by T3, or by a new fetch.
    assert_t2_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_now == TS_T2) |=> (t_now inside {TS_T2, TS_T3, TS_T1}));

endmodule

// File: rtl/cs_stretch.sv
// Refresh stretch detector.
// Flags the single half after a refresh /MREQ rise that falls in a low
// CPU clock half of a video fetch. When ENABLE is 0 it never flags.
module cs_stretch #(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_phase,
    input  logic mreq_n,
    input  logic rfsh_n,
    input  logic vid_q,
    output logic stretch
);

    generate
        if (ENABLE) begin : g_on
            logic mreq_prev;
            logic rfsh_prev;

            // Remember last half's memory request and refresh strobes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mreq_prev <= 1'b1;
                    rfsh_prev <= 1'b1;
                end else begin
                    mreq_prev <= mreq_n;
                    rfsh_prev <= rfsh_n;
                end
            end

            // Extend only a refresh request that ends in a low clock half.
            assign stretch = mreq_n & ~mreq_prev & ~rfsh_prev & ~cpu_phase & vid_q;

            // R3: a stretch never lasts more than one half.
            assert_stretch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
                stretch |=> !stretch);
        end else begin : g_off
            logic unused_stretch_in;
            assign unused_stretch_in = ^{clk, rst_n, cpu_phase, mreq_n, rfsh_n, vid_q};
            assign stretch = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cs_select.sv
// Select combiner.
// Builds the active-low selects for the chosen variant, steers them with
// a14 and applies force-NOP blanking during T2/T3 when enabled.
// Purely combinational.
module cs_select
    import cs_pkg::*;
#(
    parameter bit STRETCH_VARIANT = 1'b1,
    parameter bit BLANK_ON_NOP    = 1'b1
) (
    input  logic    mreq_n,
    input  logic    rfsh_n,
    input  logic    a14,
    input  logic    stretch,
    input  logic    force_nop,
    input  tstate_e t_now,
    output logic    rom_cs_n,
    output logic    ram_cs_n
);

    logic blank;
    logic rom_on;
    logic ram_on;

    // Blanking window: force-NOP held during T2 or T3 of a fetch.
    generate
        if (BLANK_ON_NOP) begin : g_blank
            assign blank = force_nop & ((t_now == TS_T2) | (t_now == TS_T3));
        end else begin : g_noblank
            logic unused_blank_in;
            assign unused_blank_in = ^{force_nop, t_now};
            assign blank = 1'b0;
        end
    endgenerate

    // Per-variant select equations before blanking.
    generate
        if (STRETCH_VARIANT) begin : g_str
            logic unused_rfsh_in;
            assign unused_rfsh_in = rfsh_n;
            assign rom_on = (~mreq_n | stretch) & ~a14;
            assign ram_on = (~mreq_n | stretch) & a14;
        end else begin : g_rf
            logic unused_stretch_in;
            assign unused_stretch_in = stretch;
            assign rom_on = (~mreq_n & ~a14) | ~rfsh_n;
            assign ram_on = ~mreq_n & a14 & rfsh_n;
        end
    endgenerate

    // Drive the active-low outputs.
    always_comb begin
        rom_cs_n = ~(rom_on & ~blank);
        ram_cs_n = ~(ram_on & ~blank);
    end

endmodule

// File: rtl/cs_decode.sv
// Memory select generator, top level.
// Tracks T-states, latches the video flag at /M1 fall, detects the
// refresh stretch and combines everything into active-low ROM and RAM
// selects. Runs on a clock at twice the CPU rate; cpu_phase gives the
// CPU clock level of each half.
module cs_decode
    import cs_pkg::*;
#(
    parameter bit STRETCH_VARIANT = 1'b1,
    parameter bit BLANK_ON_NOP    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_phase,
    input  logic m1_n,
    input  logic mreq_n,
    input  logic rfsh_n,
    input  logic a14,
    input  logic video_en,
    input  logic force_nop,
    output logic rom_cs_n,
    output logic ram_cs_n
);

    tstate_e t_now;
    logic    vid_q;
    logic    stretch;

    cs_tstate_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_phase (cpu_phase),
        .m1_n      (m1_n),
        .video_en  (video_en),
        .t_now     (t_now),
        .vid_q     (vid_q)
    );

    cs_stretch #(.ENABLE(STRETCH_VARIANT)) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_phase (cpu_phase),
        .mreq_n    (mreq_n),
        .rfsh_n    (rfsh_n),
        .vid_q     (vid_q),
        .stretch   (stretch)
    );

    cs_select #(
        .STRETCH_VARIANT (STRETCH_VARIANT),
        .BLANK_ON_NOP    (BLANK_ON_NOP)
    ) u_select (
        .mreq_n    (mreq_n),
        .rfsh_n    (rfsh_n),
        .a14       (a14),
        .stretch   (stretch),
        .force_nop (force_nop),
        .t_now     (t_now),
        .rom_cs_n  (rom_cs_n),
        .ram_cs_n  (ram_cs_n)
    );

    // R1: the two selects are never active together.
    assert_one_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_cs_n && !ram_cs_n));

    // R8: inside the blanking window both selects stay inactive.
    assert_blank_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (BLANK_ON_NOP && force_nop && (t_now == TS_T2 || t_now == TS_T3))
            |-> (rom_cs_n && ram_cs_n));

    // R3: a select active without /MREQ must follow a request, in a low half.
    generate
        if (STRETCH_VARIANT) begin : g_chk_str
            assert_stretch_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ((!rom_cs_n || !ram_cs_n) && mreq_n) |-> ($past(!mreq_n) && !cpu_phase));
        end
    endgenerate

endmodule

// File: tb/tb_cs_decode.sv
`timescale 1ns/1ps
// Bench: replays fetch and read cycles half by half over both variants.
module tb_cs_decode;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_phase = 1'b1;
    logic m1_n = 1'b1;
    logic mreq_n = 1'b1;
    logic rfsh_n = 1'b1;
    logic a14 = 1'b0;
    logic video_en = 1'b0;
    logic force_nop = 1'b0;
    logic rom_s, ram_s, rom_r, ram_r;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    cs_decode #(.STRETCH_VARIANT(1'b1), .BLANK_ON_NOP(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_phase(cpu_phase), .m1_n(m1_n),
        .mreq_n(mreq_n), .rfsh_n(rfsh_n), .a14(a14), .video_en(video_en),
        .force_nop(force_nop), .rom_cs_n(rom_s), .ram_cs_n(ram_s));

    cs_decode #(.STRETCH_VARIANT(1'b0), .BLANK_ON_NOP(1'b0)) dut_alt (
        .clk(clk), .rst_n(rst_n), .cpu_phase(cpu_phase), .m1_n(m1_n),
        .mreq_n(mreq_n), .rfsh_n(rfsh_n), .a14(a14), .video_en(video_en),
        .force_nop(force_nop), .rom_cs_n(rom_r), .ram_cs_n(ram_r));

    task automatic chk(input string tag, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, got, exp);
        end
    endtask

    // kind 0: opcode fetch + refresh (8 halves); kind 1: memory read (6 halves).
    task automatic run_cycle(input int kind, input bit vf, input bit vr,
                             input bit fn, input bit a);
        int nh;
        nh = (kind == 0) ? 8 : 6;
        for (int h = 0; h < nh; h++) begin
            bit  sel, str, blk, e_rom_r, e_ram_r;
            string tag;
            @(negedge clk);
            cpu_phase = (h % 2 == 0);
            a14       = a;
            force_nop = fn;
            if (kind == 0) begin
                m1_n     = !(h <= 3);
                mreq_n   = !((h >= 1 && h <= 3) || h == 5 || h == 6);
                rfsh_n   = !(h >= 4);
                video_en = (h == 0) ? vf : vr;
            end else begin
                m1_n     = 1'b1;
                mreq_n   = !(h >= 1 && h <= 4);
                rfsh_n   = 1'b1;
                video_en = vr;
            end
            #1;
            str = (kind == 0) && (h == 7) && vf;
            blk = (kind == 0) && fn && (h >= 2 && h <= 5);
            sel = (!mreq_n || str) && !blk;
            if (kind == 0 && h == 7)
                tag = (vf != vr) ? "R5" : (vf ? (a ? "R6" : "R3") : "R4");
            else if (fn)
                tag = "R8";
            else if (kind == 1 && h == 5)
                tag = "R4";
            else
                tag = "R2";
            chk(tag, "stretch rom_cs_n", rom_s, !(sel && !a));
            chk(tag, "stretch ram_cs_n", ram_s, !(sel && a));
            chk("R1", "not both low", !(!rom_s && !ram_s), 1'b1);
            e_rom_r = !((!mreq_n && !a) || !rfsh_n);
            e_ram_r = !(!mreq_n && a && rfsh_n);
            chk(fn ? "R9" : "R7", "refresh-variant rom_cs_n", rom_r, e_rom_r);
            chk(fn ? "R9" : "R7", "refresh-variant ram_cs_n", ram_r, e_ram_r);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R10", "reset rom_cs_n", rom_s, 1'b1);
        chk("R10", "reset ram_cs_n", ram_s, 1'b1);
        chk("R10", "reset alt rom_cs_n", rom_r, 1'b1);
        rst_n = 1'b1;
        // First fetch after reset with the flag off: no stretch from a stale flag.
        run_cycle(0, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int vf = 0; vf < 2; vf++)
            for (int vr = 0; vr < 2; vr++)
                for (int fn = 0; fn < 2; fn++)
                    for (int a = 0; a < 2; a++) begin
                        run_cycle(0, vf[0], vr[0], fn[0], a[0]);
                        run_cycle(1, vf[0], vf[0], fn[0], a[0]);
                    end
        // Back-to-back fetches: the latched flag follows each /M1 fall.
        run_cycle(0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_cycle(0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_cycle(0, 1'b1, 1'b0, 1'b1, 1'b1);
        // Reset clears the flag: after a flagged fetch, a reset, then a
        // refresh-only pattern with no new /M1 fall must not stretch.
        run_cycle(0, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int h = 4; h < 8; h++) begin
            @(negedge clk);
            cpu_phase = (h % 2 == 0);
            m1_n      = 1'b1;
            mreq_n    = !(h == 5 || h == 6);
            rfsh_n    = 1'b0;
            force_nop = 1'b0;
            a14       = 1'b0;
            #1;
            chk("R10", "no stretch after reset", rom_s, !(h == 5 || h == 6));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule